// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port

This block is the digital output side of one sampling converter that can be strung together with others on a three-wire serial bus: a convert strobe, a serial clock and a data line. The host raises the convert strobe while the serial clock is low. That starts a conversion of fixed length, modelled here by an internal timer counted in system clock cycles. When the timer expires, the parallel result is loaded into a shift register and its most significant bit appears on the serial output at once.

Each falling edge of the serial clock then moves the register by one place. The next result bit goes out, and the level on the chain input is taken into the least significant position. Once its own word has left, the device therefore passes on whatever the upstream device sent it. A host reading N chained devices clocks 16 × N bits with the strobe held high. Dropping the strobe ends the sequence and forces the output low.

The three bus inputs are asynchronous to the system clock. They pass through a synchronizer, and their edges are detected in the system clock domain.

Top module: `chain_adc_port`

## Requirements
- R1: After reset, `sdo_o` is 0.
- R2: Whenever the synchronized convert strobe is low, `sdo_o` is 0 from the following system clock cycle, and any readback in progress is abandoned.
- R3: A rising edge of `cnv_i` starts a conversion only if `sck_i` is low at that edge. With `sck_i` high, no conversion starts and `sdo_o` stays 0 for as long as the strobe stays high.
- R4: While a conversion runs, `sdo_o` stays 0 and falling edges of `sck_i` have no effect on the data later shifted out.
- R5: `sdo_o` carries bit 15 of `sample_i` exactly CONV_CYCLES+3 system clock edges after `cnv_i` rises. That delay is two synchronizer stages, one edge-detect stage and CONV_CYCLES cycles of conversion. One cycle earlier, `sdo_o` is still 0.
- R6: In readback, each falling edge of `sck_i` presents the next bit on `sdo_o` three system clock edges after the edge, and rising edges of `sck_i` leave `sdo_o` unchanged.
- R7: The result is shifted out most significant bit first. After falling edge k with k from 1 to 15, `sdo_o` equals sample bit 15−k.
- R8: The `sdi_i` level at each falling edge enters the least significant bit of the register. After falling edge k with k from 16 to 31, `sdo_o` equals the `sdi_i` value captured at falling edge k−15, so an upstream word follows the device's own word MSB first.
- R9: A new conversion started after a partial readback discards the unshifted bits. Only the new sample is read out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Convert strobe, asynchronous |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Chain input from the upstream device, asynchronous |
| sample_i | input | W | Parallel conversion result, taken when the conversion ends |
| sdo_o | output | 1 | Serial data output, registered |

## Verification
Readback is exercised with several pairs of sample word and upstream word: alternating bits, all ones against all zeros, and irregular values. Together these separate a correct MSB-first order from a reversed order, a stuck output, and an upstream word that fails to follow the device's own bits. During each conversion the serial clock is toggled, which shows whether edges leak into the shift path. Every readback also checks the exact cycle in which the MSB first appears. Further cases are a strobe rising while the serial clock is high, which must not start a conversion, and a strobe dropped in mid-readback followed by a fresh conversion, which must show only the new word.

// File: rtl/chain_port_pkg.sv
package chain_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } port_state_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic abort_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= CW'(CYCLES - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

  // R5: a start loads the full conversion length
  p_start_loads_r5: assert property (@(posedge clk) disable iff (rst)
    (start_i && !abort_i) |=> (run_q && cnt_q == CW'(CYCLES - 1)));
  // R5: completion is a single-cycle pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> !done_o);
endmodule

// File: rtl/chain_shreg.sv
module chain_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  input  logic         ser_i,
  output logic         msb_o
);
  logic [W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  reg_q <= '0;
    else if (load_i)   reg_q <= data_i;
    else if (shift_i)  reg_q <= {reg_q[W-2:0], ser_i};
  end

  assign msb_o = reg_q[W-1];

  // R6: without a command the output bit holds
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_i && !shift_i) |=> $stable(msb_o));
  // R8: a shift presents the neighbouring bit
  p_shift_next_r8: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !clr_i && !load_i) |=> (msb_o == $past(reg_q[W-2])));
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port
  import chain_port_pkg::*;
#(
  parameter int W           = 16,
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnv_i,
  input  logic         sck_i,
  input  logic         sdi_i,
  input  logic [W-1:0] sample_i,
  output logic         sdo_o
);
  logic [2:0]  sync_w;
  logic        cnv_s, sck_s, sdi_s;
  logic        cnv_d, sck_d;
  logic        cnv_rise, sck_fall;
  logic        tmr_start, tmr_abort, tmr_done;
  logic        sh_clr, sh_load, sh_shift;
  port_state_t state_q, state_n;

  bus_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({sdi_i, sck_i, cnv_i}),
    .sync_o  (sync_w)
  );

  assign cnv_s = sync_w[0];
  assign sck_s = sync_w[1];
  assign sdi_s = sync_w[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnv_d <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      cnv_d <= cnv_s;
      sck_d <= sck_s;
    end
  end

  assign cnv_rise = cnv_s && !cnv_d;
  assign sck_fall = !sck_s && sck_d;

  always_comb begin
    state_n   = state_q;
    tmr_start = 1'b0;
    tmr_abort = 1'b0;
    sh_clr    = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    if (!cnv_s) begin
      state_n   = ST_IDLE;
      tmr_abort = 1'b1;
      sh_clr    = 1'b1;
    end else if (cnv_rise) begin
      sh_clr = 1'b1;
      if (!sck_s) begin
        state_n   = ST_CONV;
        tmr_start = 1'b1;
      end else begin
        state_n   = ST_IDLE;
        tmr_abort = 1'b1;
      end
    end else begin
      case (state_q)
        ST_CONV: if (tmr_done) begin
          sh_load = 1'b1;
          state_n = ST_READ;
        end
        ST_READ: sh_shift = sck_fall;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_n;
  end

  conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (tmr_start),
    .abort_i (tmr_abort),
    .done_o  (tmr_done)
  );

  chain_shreg #(.W(W)) u_shreg (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (sh_clr),
    .load_i  (sh_load),
    .shift_i (sh_shift),
    .data_i  (sample_i),
    .ser_i   (sdi_s),
    .msb_o   (sdo_o)
  );

  // R2: a low strobe forces the line low on the next cycle
  p_cnv_low_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !cnv_s |=> !sdo_o);
  // R3: strobe edge with the serial clock high starts nothing
  p_no_start_sck_high_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && cnv_rise && sck_s) |=> (state_q == ST_IDLE));
  // R4: line stays low during conversion
  p_quiet_conv_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV) |-> !sdo_o);
  // R5: completion puts the sample MSB on the line
  p_msb_on_done_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && tmr_done && cnv_s && !cnv_rise)
      |=> (state_q == ST_READ && sdo_o == $past(sample_i[W-1])));
endmodule

// File: tb/tb_chain_adc_port.sv
module tb_chain_adc_port;
  localparam int W  = 16;
  localparam int CC = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnv = 1'b0;
  logic         sck = 1'b0;
  logic         sdi = 1'b0;
  logic [W-1:0] smp = '0;
  logic         sdo;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  chain_adc_port #(.W(W), .CONV_CYCLES(CC), .SYNC_STAGES(2)) dut (
    .clk      (clk),
    .rst      (rst),
    .cnv_i    (cnv),
    .sck_i    (sck),
    .sdi_i    (sdi),
    .sample_i (smp),
    .sdo_o    (sdo)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: sdo=%b expected %b", req, what, got, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    tick(3);
    check(sdo, 1'b0, "R1", "during reset");
    rst = 1'b0;
    tick(2);
    check(sdo, 1'b0, "R1", "after reset");
  endtask

  // conversion with sck toggled during it, exact MSB timing check
  task automatic start_conv(input logic [W-1:0] s);
    smp = s;
    cnv = 1'b1;
    tick(4);
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
    tick(CC + 2 - 8);
    check(sdo, 1'b0, "R4", "low until conversion done");
    tick(1);
    check(sdo, s[W-1], "R5", "MSB at CONV_CYCLES+3");
  endtask

  task automatic t_readback(input logic [W-1:0] s, input logic [W-1:0] up);
    logic exp;
    start_conv(s);
    exp = s[W-1];
    for (int k = 1; k <= 2 * W - 1; k++) begin
      sck = 1'b1;
      tick(4);
      check(sdo, exp, "R6", $sformatf("rise %0d no change", k));
      sck = 1'b0;
      sdi = (k <= W) ? up[W - k] : 1'b0;
      tick(4);
      if (k < W) begin
        exp = s[W - 1 - k];
        check(sdo, exp, "R7", $sformatf("own bit after fall %0d", k));
      end else begin
        exp = up[2 * W - 1 - k];
        check(sdo, exp, "R8", $sformatf("chained bit after fall %0d", k));
      end
    end
    cnv = 1'b0;
    sdi = 1'b0;
    tick(3);
    check(sdo, 1'b0, "R2", "strobe low after readback");
  endtask

  task automatic t_sck_high_start;
    smp = 16'hFFFF;
    sck = 1'b1;
    tick(4);
    cnv = 1'b1;
    tick(CC + 10);
    check(sdo, 1'b0, "R3", "no conversion with sck high");
    sck = 1'b0;
    tick(6);
    check(sdo, 1'b0, "R3", "still idle after sck drops");
    cnv = 1'b0;
    tick(4);
  endtask

  task automatic t_restart;
    start_conv(16'hA5C3);
    for (int k = 1; k <= 5; k++) begin
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
      sdi = 1'b1;
      tick(4);
    end
    cnv = 1'b0;
    tick(3);
    check(sdo, 1'b0, "R2", "abandoned readback goes low");
    sdi = 1'b0;
    tick(2);
    start_conv(16'h4000);
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
    tick(4);
    check(sdo, 1'b1, "R9", "new sample bit 14 after restart");
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
    tick(4);
    check(sdo, 1'b0, "R9", "new sample bit 13 after restart");
    cnv = 1'b0;
    tick(4);
  endtask

  initial begin
    t_reset();
    t_readback(16'hAAAA, 16'h5555);
    t_readback(16'hFFFF, 16'h0000);
    t_readback(16'h1234, 16'hC0DE);
    t_sck_high_start();
    t_restart();
    t_readback(16'h8001, 16'h7FFE);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule